// File: doc/BRIEF.md
# Transactional Conflict List Tracker

This unit sits beside one core of a multi-core system and keeps an exact record of which other cores' transactions conflict with the transaction running locally. Conflicts are detected eagerly, as the coherence layer reports shared lines, but nothing is resolved until commit time. Two bit vectors are held, one bit per core. The racers vector lists the remote transactions this core will abort if it commits first. The killers vector lists the remote transactions allowed to abort this core if they commit first.

A conflict notice carries a remote core number and two flags: whether the local access to the shared line was a write, and whether the remote access was a write. On commit, the tracker sends one abort request mask covering every racer. It then waits until each racer has acknowledged. A transaction with no racers commits on the next cycle without waiting, so independent transactions on different cores never serialize. Incoming aborts are honoured only from listed killers, and every incoming abort is acknowledged. Line storage, checkpointing and the network are outside the block.

Top module: `txn_conflict_tracker`

## Requirements
- R1: After reset the tracker is idle, both vectors are zero, and commit_done, core_abort, abort_req_valid and ack_out_valid are low.
- R2: A conflict notice with conf_local_wr=0 and conf_remote_wr=0 (read-read sharing) changes neither vector.
- R3: While a transaction is active, a conflict notice with conf_local_wr=1 sets bit conf_core of the racers vector on the following cycle.
- R4: While a transaction is active, a conflict notice with conf_remote_wr=1 sets bit conf_core of the killers vector on the following cycle. When both flags are 1, both vectors are set.
- R5: The tracker's own bit (CORE_ID) is never set in either vector. Conflict notices that arrive while no transaction is active are ignored.
- R6: commit_req on an active transaction with an empty racers vector raises commit_done for one cycle on the next cycle. No abort request is issued in that case.
- R7: commit_req with a non-empty racers vector raises abort_req_valid for one cycle on the next cycle, with abort_req_mask equal to the racers vector. commit_done is raised one cycle after the acknowledgement that clears the last outstanding racer, and never earlier.
- R8: While waiting, an acknowledgement from a core that is not outstanding, or a repeated acknowledgement, has no effect.
- R9: While a transaction is active and not committing, an incoming abort from a core whose killers bit is set raises core_abort for one cycle on the next cycle and ends the transaction.
- R10: An incoming abort is ignored, with no core_abort and no change of state, if the sender's killers bit is clear, if no transaction is active, or if a commit is in progress.
- R11: Every incoming abort is answered on the next cycle with ack_out_valid=1 and ack_out_core equal to the sender's number.
- R12: Both vectors are zero after a transaction begins, completes its commit, or is aborted.
- R13: tx_begin is accepted only while idle. In an active transaction, a valid incoming abort takes priority over commit_req, and commit_req takes priority over a conflict notice in the same cycle, which is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_begin | input | 1 | Start a transaction |
| commit_req | input | 1 | Local transaction reached its commit point |
| conf_valid | input | 1 | Conflict notice valid |
| conf_core | input | IW | Remote core of the conflict notice |
| conf_local_wr | input | 1 | Local access to the shared line was a write |
| conf_remote_wr | input | 1 | Remote access to the shared line was a write |
| abort_in_valid | input | 1 | Abort request arriving from a remote committer |
| abort_in_core | input | IW | Sender of the incoming abort |
| ack_in_valid | input | 1 | Abort acknowledgement arriving from a racer |
| ack_in_core | input | IW | Sender of the acknowledgement |
| racers | output | N | Cores to abort on a local commit |
| killers | output | N | Cores allowed to abort this core |
| tx_active | output | 1 | Transaction running, not committing |
| commit_busy | output | 1 | Waiting for abort acknowledgements |
| abort_req_valid | output | 1 | One-cycle abort request issue |
| abort_req_mask | output | N | Cores addressed by the abort request |
| commit_done | output | 1 | One-cycle commit completion |
| core_abort | output | 1 | One-cycle abort to the local core |
| ack_out_valid | output | 1 | Acknowledgement of an incoming abort |
| ack_out_core | output | IW | Core the acknowledgement goes to |

## Verification
Every remote core is paired with all four combinations of local and remote write flags, including the tracker's own number. This separates read-read sharing from the three conflict cases, and racers from killers. Every legal racers mask is then committed, with acknowledgements taken one at a time and interleaved with stray and repeated ones. This shows that completion waits for exactly the listed cores, and that an empty mask commits at once. Incoming aborts come from killers, from non-killers, while idle and while committing. Colliding inputs in one cycle check the order of precedence.

// File: rtl/tct_pkg.sv
package tct_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_COMMIT = 2'd2
  } tx_state_t;
endpackage

// File: rtl/tct_vec.sv
// One conflict bit vector with one bit per core; clear has priority over set.
module tct_vec #(
  parameter int N    = 8,
  parameter int IW   = 3,
  parameter int SELF = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  output logic [N-1:0]  vec
);
  localparam logic [IW-1:0] SELF_ID = IW'(SELF);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      vec <= '0;
    end else if (set_en && (set_idx != SELF_ID)) begin
      vec[set_idx] <= 1'b1;
    end
  end

  // R5: the tracker's own core never appears as a conflicting peer
  assert_self_bit_clear_R5: assert property (@(posedge clk) disable iff (rst)
    !vec[SELF]);
endmodule

// File: rtl/tct_ctrl.sv
// Transaction state, commit handshake with racers, and incoming abort decision.
module tct_ctrl
  import tct_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tx_begin,
  input  logic          commit_req,
  input  logic          abort_in_valid,
  input  logic [IW-1:0] abort_in_core,
  input  logic          ack_in_valid,
  input  logic [IW-1:0] ack_in_core,
  input  logic [N-1:0]  racers,
  input  logic [N-1:0]  killers,
  output tx_state_t     state,
  output logic          rec_en,
  output logic          clr_vec,
  output logic          abort_req_valid,
  output logic [N-1:0]  abort_req_mask,
  output logic          commit_done,
  output logic          core_abort
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0] pending;
  logic [N-1:0] ack_bits;
  logic [N-1:0] pend_next;
  logic         take_abort;
  logic         start_commit;
  logic         fast_commit;
  logic         finish_wait;

  always_comb begin
    take_abort   = (state == ST_ACTIVE) && abort_in_valid && killers[abort_in_core];
    start_commit = (state == ST_ACTIVE) && !take_abort && commit_req;
    fast_commit  = start_commit && (racers == '0);
    ack_bits     = ack_in_valid ? (ONE << ack_in_core) : '0;
    pend_next    = pending & ~ack_bits;
    finish_wait  = (state == ST_COMMIT) && (pend_next == '0);
    rec_en       = (state == ST_ACTIVE) && !take_abort && !commit_req;
    clr_vec      = ((state == ST_IDLE) && tx_begin) || take_abort || fast_commit || finish_wait;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state           <= ST_IDLE;
      pending         <= '0;
      abort_req_valid <= 1'b0;
      abort_req_mask  <= '0;
      commit_done     <= 1'b0;
      core_abort      <= 1'b0;
    end else begin
      abort_req_valid <= 1'b0;
      commit_done     <= 1'b0;
      core_abort      <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (tx_begin) state <= ST_ACTIVE;
        end
        ST_ACTIVE: begin
          if (take_abort) begin
            state      <= ST_IDLE;
            core_abort <= 1'b1;
          end else if (fast_commit) begin
            state       <= ST_IDLE;
            commit_done <= 1'b1;
          end else if (start_commit) begin
            state           <= ST_COMMIT;
            pending         <= racers;
            abort_req_valid <= 1'b1;
            abort_req_mask  <= racers;
          end
        end
        ST_COMMIT: begin
          pending <= pend_next;
          if (finish_wait) begin
            state       <= ST_IDLE;
            commit_done <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: completion only once no acknowledgement is outstanding
  assert_done_no_pending_R7: assert property (@(posedge clk) disable iff (rst)
    commit_done |-> (pending == '0));
  // R7: the waiting state always has someone left to hear from
  assert_wait_nonempty_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_COMMIT) |-> (pending != '0));
  // R7: an abort request is issued exactly when the wait begins
  assert_req_in_wait_R7: assert property (@(posedge clk) disable iff (rst)
    abort_req_valid |-> ((state == ST_COMMIT) && (pending == abort_req_mask)));
  // R13: outcomes of one cycle are mutually exclusive
  assert_one_outcome_R13: assert property (@(posedge clk) disable iff (rst)
    $onehot0({commit_done, core_abort, abort_req_valid}));
  // R9: a local abort always leaves the tracker idle
  assert_abort_idle_R9: assert property (@(posedge clk) disable iff (rst)
    core_abort |-> (state == ST_IDLE));
endmodule

// File: rtl/txn_conflict_tracker.sv
module txn_conflict_tracker
  import tct_pkg::*;
#(
  parameter int N       = 8,
  parameter int CORE_ID = 0,
  parameter int IW      = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tx_begin,
  input  logic          commit_req,
  input  logic          conf_valid,
  input  logic [IW-1:0] conf_core,
  input  logic          conf_local_wr,
  input  logic          conf_remote_wr,
  input  logic          abort_in_valid,
  input  logic [IW-1:0] abort_in_core,
  input  logic          ack_in_valid,
  input  logic [IW-1:0] ack_in_core,
  output logic [N-1:0]  racers,
  output logic [N-1:0]  killers,
  output logic          tx_active,
  output logic          commit_busy,
  output logic          abort_req_valid,
  output logic [N-1:0]  abort_req_mask,
  output logic          commit_done,
  output logic          core_abort,
  output logic          ack_out_valid,
  output logic [IW-1:0] ack_out_core
);
  tx_state_t state;
  logic      rec_en;
  logic      clr_vec;

  tct_ctrl #(.N(N), .IW(IW)) u_ctrl (
    .clk(clk), .rst(rst), .tx_begin(tx_begin), .commit_req(commit_req),
    .abort_in_valid(abort_in_valid), .abort_in_core(abort_in_core),
    .ack_in_valid(ack_in_valid), .ack_in_core(ack_in_core),
    .racers(racers), .killers(killers), .state(state),
    .rec_en(rec_en), .clr_vec(clr_vec),
    .abort_req_valid(abort_req_valid), .abort_req_mask(abort_req_mask),
    .commit_done(commit_done), .core_abort(core_abort)
  );

  // local write on a shared line: the remote reader/writer is a racer
  tct_vec #(.N(N), .IW(IW), .SELF(CORE_ID)) u_racers (
    .clk(clk), .rst(rst), .clr(clr_vec),
    .set_en(rec_en && conf_valid && conf_local_wr),
    .set_idx(conf_core), .vec(racers)
  );

  // remote write on a shared line: the remote writer is a killer
  tct_vec #(.N(N), .IW(IW), .SELF(CORE_ID)) u_killers (
    .clk(clk), .rst(rst), .clr(clr_vec),
    .set_en(rec_en && conf_valid && conf_remote_wr),
    .set_idx(conf_core), .vec(killers)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_out_valid <= 1'b0;
      ack_out_core  <= '0;
    end else begin
      ack_out_valid <= abort_in_valid;
      ack_out_core  <= abort_in_core;
    end
  end

  assign tx_active   = (state == ST_ACTIVE);
  assign commit_busy = (state == ST_COMMIT);

  // R11: every incoming abort is answered to its sender
  assert_abort_answered_R11: assert property (@(posedge clk) disable iff (rst)
    abort_in_valid |=> (ack_out_valid && (ack_out_core == $past(abort_in_core))));
  // R2: read-read sharing leaves both vectors untouched
  assert_read_read_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (conf_valid && !conf_local_wr && !conf_remote_wr && tx_active &&
     !abort_in_valid && !commit_req) |=> ($stable(racers) && $stable(killers)));
  // R5: nothing is recorded outside a running transaction
  assert_idle_no_record_R5: assert property (@(posedge clk) disable iff (rst)
    (!tx_active && !commit_busy && !tx_begin) |=> ((racers == '0) && (killers == '0)));
endmodule

// File: tb/txn_conflict_tracker_test.sv
`timescale 1ns/1ps
module txn_conflict_tracker_test;
  localparam int N    = 4;
  localparam int SELF = 1;
  localparam int IW   = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tx_begin = 0, commit_req = 0, conf_valid = 0;
  logic [IW-1:0] conf_core = 0;
  logic          conf_local_wr = 0, conf_remote_wr = 0;
  logic          abort_in_valid = 0, ack_in_valid = 0;
  logic [IW-1:0] abort_in_core = 0, ack_in_core = 0;
  logic [N-1:0]  racers, killers, abort_req_mask;
  logic          tx_active, commit_busy, abort_req_valid, commit_done, core_abort;
  logic          ack_out_valid;
  logic [IW-1:0] ack_out_core;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  txn_conflict_tracker #(.N(N), .CORE_ID(SELF), .IW(IW)) uut (
    .clk(clk), .rst(rst), .tx_begin(tx_begin), .commit_req(commit_req),
    .conf_valid(conf_valid), .conf_core(conf_core),
    .conf_local_wr(conf_local_wr), .conf_remote_wr(conf_remote_wr),
    .abort_in_valid(abort_in_valid), .abort_in_core(abort_in_core),
    .ack_in_valid(ack_in_valid), .ack_in_core(ack_in_core),
    .racers(racers), .killers(killers), .tx_active(tx_active),
    .commit_busy(commit_busy), .abort_req_valid(abort_req_valid),
    .abort_req_mask(abort_req_mask), .commit_done(commit_done),
    .core_abort(core_abort), .ack_out_valid(ack_out_valid),
    .ack_out_core(ack_out_core)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // inputs are driven after a falling edge; one rising edge later, sample at the next falling edge
  task automatic step();
    @(negedge clk);
    tx_begin = 0; commit_req = 0; conf_valid = 0; conf_local_wr = 0;
    conf_remote_wr = 0; abort_in_valid = 0; ack_in_valid = 0;
  endtask

  task automatic conflict(input int c, input logic lw, input logic rw);
    conf_valid = 1; conf_core = IW'(c); conf_local_wr = lw; conf_remote_wr = rw;
    step();
  endtask

  task automatic ack(input int c);
    ack_in_valid = 1; ack_in_core = IW'(c);
    step();
  endtask

  task automatic begin_tx();
    tx_begin = 1;
    step();
    check("R12 begin clears racers", 32'(racers), 0);
    check("R12 begin clears killers", 32'(killers), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    step();
    check("R1 racers", 32'(racers), 0);
    check("R1 killers", 32'(killers), 0);
    check("R1 idle", 32'({tx_active, commit_busy}), 0);
    check("R1 pulses", 32'({commit_done, core_abort, abort_req_valid, ack_out_valid}), 0);

    // R5: conflict notice while idle is dropped
    conflict(0, 1, 1);
    check("R5 idle notice racers", 32'(racers), 0);
    check("R5 idle notice killers", 32'(killers), 0);

    // R2 R3 R4 R5: every remote core against every access-flag pair
    for (int r = 0; r < N; r++) begin
      for (int t = 0; t < 4; t++) begin
        logic lw, rw;
        logic [N-1:0] er, ek;
        lw = t[0]; rw = t[1];
        er = (lw && r != SELF) ? (N'(1) << r) : '0;
        ek = (rw && r != SELF) ? (N'(1) << r) : '0;
        begin_tx();
        conflict(r, lw, rw);
        check("R2 R3 R5 racers after notice", 32'(racers), 32'(er));
        check("R2 R4 R5 killers after notice", 32'(killers), 32'(ek));
        commit_req = 1;
        step();
        if (er != 0) begin
          check("R7 abort request issued", 32'(abort_req_valid), 1);
          check("R7 abort mask", 32'(abort_req_mask), 32'(er));
          check("R7 no early done", 32'(commit_done), 0);
          ack(r);
          check("R7 done after ack", 32'(commit_done), 1);
        end else begin
          check("R6 fast commit done", 32'(commit_done), 1);
          check("R6 no abort request", 32'(abort_req_valid), 0);
        end
        check("R12 commit clears", 32'({racers, killers}), 0);
        check("R6 R7 back to idle", 32'({tx_active, commit_busy}), 0);
      end
    end

    // R7 R8: every racers mask without the own bit, acks from the top down
    for (int m = 0; m < (1 << N); m++) begin
      int left;
      if (m[SELF]) continue;
      begin_tx();
      left = 0;
      for (int c = 0; c < N; c++) if (m[c]) begin conflict(c, 1, 0); left++; end
      check("R3 racers mask built", 32'(racers), 32'(m));
      commit_req = 1;
      step();
      if (m == 0) begin
        check("R6 empty mask commits", 32'(commit_done), 1);
        continue;
      end
      check("R7 mask sent", 32'(abort_req_mask), 32'(m));
      ack(SELF);
      check("R8 stray ack ignored", 32'(commit_done), 0);
      check("R8 still waiting", 32'(commit_busy), 1);
      for (int c = N - 1; c >= 0; c--) begin
        if (!m[c]) continue;
        ack(c);
        left--;
        check("R7 done only on last ack", 32'(commit_done), (left == 0) ? 1 : 0);
        if (left != 0) begin
          ack(c);
          check("R8 repeated ack ignored", 32'(commit_done), 0);
        end
      end
      check("R12 cleared after commit", 32'(racers), 0);
    end

    // R9 R10 R11: incoming aborts while active
    begin_tx();
    conflict(2, 0, 1);
    check("R4 killer recorded", 32'(killers), 32'h4);
    abort_in_valid = 1; abort_in_core = 2'd3;
    step();
    check("R10 non-killer ignored", 32'(core_abort), 0);
    check("R10 still active", 32'(tx_active), 1);
    check("R11 ack to non-killer", 32'({ack_out_valid, ack_out_core}), 32'h7);
    abort_in_valid = 1; abort_in_core = 2'd2;
    step();
    check("R9 killer aborts", 32'(core_abort), 1);
    check("R9 ends tx", 32'(tx_active), 0);
    check("R12 abort clears", 32'(killers), 0);
    check("R11 ack to killer", 32'({ack_out_valid, ack_out_core}), 32'h6);
    abort_in_valid = 1; abort_in_core = 2'd2;
    step();
    check("R10 idle abort ignored", 32'(core_abort), 0);
    check("R11 ack while idle", 32'({ack_out_valid, ack_out_core}), 32'h6);

    // R13: priorities in one cycle
    begin_tx();
    conflict(0, 0, 1);
    conflict(2, 1, 0);
    tx_begin = 1;
    step();
    check("R13 begin ignored while active", 32'(racers), 32'h4);
    abort_in_valid = 1; abort_in_core = 2'd0; commit_req = 1;
    conf_valid = 1; conf_core = 2'd3; conf_local_wr = 1;
    step();
    check("R13 abort beats commit", 32'({core_abort, abort_req_valid, commit_done}), 32'h4);
    begin_tx();
    conflict(0, 0, 1);
    conflict(2, 1, 0);
    commit_req = 1; conf_valid = 1; conf_core = 2'd3; conf_local_wr = 1;
    step();
    check("R13 notice dropped under commit", 32'(abort_req_mask), 32'h4);
    abort_in_valid = 1; abort_in_core = 2'd0;
    step();
    check("R10 abort during commit ignored", 32'(core_abort), 0);
    check("R10 commit continues", 32'(commit_busy), 1);
    check("R11 ack during commit", 32'({ack_out_valid, ack_out_core}), 32'h4);
    ack(2);
    check("R7 commit completes", 32'(commit_done), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule